// File: doc/BRIEF.md
# Reference Link Cell Rate Integrator

This block measures the receive data cell rate of one group of bonded links. It watches the cell-slot strobes of every link, picks out one of them as the reference link, and counts that link's strobes over a window whose length, in system clock cycles, software sets. At the close of each window the count is placed on the rate output, a one-cycle done strobe marks the update, and the next window starts from zero with no gap.

Software chooses the reference link through a control register. If that register's automatic bit is set, the block takes the reference link number instead from octet 14 of each control cell that arrives marked good, provided the number is within the group's link count. Any change of reference link, and any write to either register, restarts the window, so a published count never mixes cells from two links.

Top module: `refrate_integrator`

## Requirements
- R1: After reset, rateOut is 0, rateDone is 0, the window length is 0 (idle), the manual link is 0 and automatic selection is off.
- R2: With window length N > 0, rateDone pulses for one cycle every N cycles, the first pulse N cycles after the restart edge, and windows follow each other with no gap.
- R3: The value published at a window's end is the number of cycles in that window in which the reference link's strobe was high; strobes on other links have no effect.
- R4: rateOut changes only in a cycle where rateDone is high and holds its value between pulses.
- R5: A write with cfgAddr = 0 sets the manual link from cfgWrData bits [LINK_W-1:0] (bits 2:0 at the default of 8 links), sets automatic mode from bit 4, loads the same link as the starting automatic link, and restarts the window without a done pulse.
- R6: A write with cfgAddr = 1 sets the window length N from cfgWrData and restarts the window; N = 0 stops all done pulses and freezes rateOut.
- R7: In automatic mode, the octet with icpOctetNum = 14, followed by icpCellEnd with icpCellOk = 1, makes that octet the reference link; if it differs from the current one, the window restarts on the edge of icpCellEnd.
- R8: In automatic mode, a cell ended with icpCellOk = 0, or an octet-14 value of NUM_LINKS or more, leaves the reference link and the running window untouched.
- R9: In manual mode, received control cells never change the reference link or disturb the window.
- R10: The count saturates at 2^COUNT_W - 1 (255 at default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellStrobe | input | NUM_LINKS | One bit per link, high for a cycle per cell slot |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 1 | 0 = reference control, 1 = window length |
| cfgWrData | input | DATA_W | Register write data |
| icpOctetValid | input | 1 | A control-cell octet is present |
| icpOctetNum | input | 6 | Position of that octet in the cell |
| icpOctet | input | 8 | Octet value |
| icpCellEnd | input | 1 | Last cycle of a control cell |
| icpCellOk | input | 1 | With icpCellEnd: the cell passed its checks |
| rateOut | output | COUNT_W | Count of the last completed window |
| rateDone | output | 1 | One-cycle pulse when rateOut is updated |

## Verification
The assertions assume that icpCellEnd never coincides with the octet-14 beat of the same cell and that register writes last a single cycle; the bench delivers each cell as a separate octet beat followed by an end beat, and pulses every write for exactly one cycle. Stimulus draws per-link strobe densities, window lengths and reference links from $urandom with a fixed seed, and adds directed cases for length 1, saturation at and around 255, mid-window writes, and in-window control cells that must be ignored.

// File: rtl/rri_pkg.sv
package rri_pkg;

  // Register selector values on cfgAddr
  localparam logic ADDR_REFCTL = 1'b0;
  localparam logic ADDR_PERIOD = 1'b1;

  // Bit of the reference control word that enables automatic selection
  localparam int AUTO_BIT = 4;

  // Octet of a control cell that carries the reference link number
  localparam logic [5:0] REF_OCTET_POS = 6'd14;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic restart;    // clear the running count, no publish
    logic windowEnd;  // publish the count and start a new window
    logic countEn;    // a window is running this cycle
  } winStrb_t;

endpackage

// File: rtl/rri_ctrl.sv
module rri_ctrl
  import rri_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int DATA_W    = 16,
  parameter int PERIOD_W  = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              icpOctetValid,
  input  logic [5:0]        icpOctetNum,
  input  logic [7:0]        icpOctet,
  input  logic              icpCellEnd,
  input  logic              icpCellOk,
  output logic [LINK_W-1:0] refLink,
  output logic              autoMode,
  output winStrb_t          strb
);

  localparam logic [8:0] LINK_LIMIT = 9'(NUM_LINKS);

  logic [LINK_W-1:0]   regLinkQ;
  logic [LINK_W-1:0]   autoLinkQ;
  logic                autoModeQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [PERIOD_W-1:0] tickQ;
  logic [7:0]          capValQ;
  logic                capHasQ;

  logic refWrite;
  logic perWrite;
  logic autoCand;
  logic autoSwitch;
  logic running;

  assign refWrite = cfgWrEn && (cfgAddr == ADDR_REFCTL);
  assign perWrite = cfgWrEn && (cfgAddr == ADDR_PERIOD);

  // A good cell whose octet 14 names a link inside the group
  assign autoCand   = icpCellEnd && icpCellOk && capHasQ &&
                      ({1'b0, capValQ} < LINK_LIMIT);
  assign autoSwitch = autoModeQ && autoCand && !cfgWrEn &&
                      (capValQ[LINK_W-1:0] != autoLinkQ);

  assign running       = (periodQ != '0);
  assign strb.restart  = cfgWrEn || autoSwitch;
  assign strb.countEn  = running && !strb.restart;
  assign strb.windowEnd = strb.countEn && (tickQ == periodQ - 1'b1);

  assign refLink  = autoModeQ ? autoLinkQ : regLinkQ;
  assign autoMode = autoModeQ;

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regLinkQ  <= '0;
      autoLinkQ <= '0;
      autoModeQ <= 1'b0;
      periodQ   <= '0;
    end else begin
      if (refWrite) begin
        regLinkQ  <= cfgWrData[LINK_W-1:0];
        autoLinkQ <= cfgWrData[LINK_W-1:0];
        autoModeQ <= cfgWrData[AUTO_BIT];
      end else if (autoModeQ && autoCand) begin
        autoLinkQ <= capValQ[LINK_W-1:0];
      end
      if (perWrite) begin
        periodQ <= cfgWrData[PERIOD_W-1:0];
      end
    end
  end

  // Octet-14 capture for the cell in flight
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValQ <= '0;
      capHasQ <= 1'b0;
    end else if (icpCellEnd) begin
      capHasQ <= 1'b0;
    end else if (icpOctetValid && (icpOctetNum == REF_OCTET_POS)) begin
      capValQ <= icpOctet;
      capHasQ <= 1'b1;
    end
  end

  // Window timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickQ <= '0;
    end else if (strb.restart || strb.windowEnd || !running) begin
      tickQ <= '0;
    end else begin
      tickQ <= tickQ + 1'b1;
    end
  end

endmodule

// File: rtl/rri_datapath.sv
module rri_datapath
  import rri_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int COUNT_W   = 8,
  localparam int LINK_W   = $clog2(NUM_LINKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINKS-1:0] cellStrobe,
  input  logic [LINK_W-1:0]    refLink,
  input  winStrb_t             strb,
  output logic [COUNT_W-1:0]   rateOut,
  output logic                 rateDone
);

  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [NUM_LINKS-1:0] hitVec;
  logic                 refHit;
  logic [COUNT_W-1:0]   cntQ;
  logic [COUNT_W-1:0]   cntNext;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_sel
    assign hitVec[i] = cellStrobe[i] && (refLink == LINK_W'(i));
  end

  assign refHit  = |hitVec;
  assign cntNext = (refHit && (cntQ != CNT_MAX)) ? cntQ + 1'b1 : cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      rateOut  <= '0;
      rateDone <= 1'b0;
    end else if (strb.restart) begin
      cntQ     <= '0;
      rateDone <= 1'b0;
    end else if (strb.windowEnd) begin
      rateOut  <= cntNext;
      cntQ     <= '0;
      rateDone <= 1'b1;
    end else begin
      rateDone <= 1'b0;
      if (strb.countEn) begin
        cntQ <= cntNext;
      end
    end
  end

endmodule

// File: rtl/refrate_integrator.sv
module refrate_integrator
  import rri_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int COUNT_W   = 8,
  parameter int DATA_W    = 16,
  parameter int PERIOD_W  = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINKS-1:0] cellStrobe,
  input  logic                 cfgWrEn,
  input  logic                 cfgAddr,
  input  logic [DATA_W-1:0]    cfgWrData,
  input  logic                 icpOctetValid,
  input  logic [5:0]           icpOctetNum,
  input  logic [7:0]           icpOctet,
  input  logic                 icpCellEnd,
  input  logic                 icpCellOk,
  output logic [COUNT_W-1:0]   rateOut,
  output logic                 rateDone
);

  winStrb_t          strb;
  logic [LINK_W-1:0] refLink;
  logic              autoMode;

  rri_ctrl #(
    .NUM_LINKS (NUM_LINKS),
    .DATA_W    (DATA_W),
    .PERIOD_W  (PERIOD_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgWrEn       (cfgWrEn),
    .cfgAddr       (cfgAddr),
    .cfgWrData     (cfgWrData),
    .icpOctetValid (icpOctetValid),
    .icpOctetNum   (icpOctetNum),
    .icpOctet      (icpOctet),
    .icpCellEnd    (icpCellEnd),
    .icpCellOk     (icpCellOk),
    .refLink       (refLink),
    .autoMode      (autoMode),
    .strb          (strb)
  );

  rri_datapath #(
    .NUM_LINKS (NUM_LINKS),
    .COUNT_W   (COUNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cellStrobe (cellStrobe),
    .refLink    (refLink),
    .strb       (strb),
    .rateOut    (rateOut),
    .rateDone   (rateDone)
  );

endmodule

// File: rtl/rri_checker.sv
module rri_checker #(
  parameter int LINK_W  = 3,
  parameter int DATA_W  = 16,
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic               cfgAddr,
  input logic [DATA_W-1:0]  cfgWrData,
  input logic               icpCellEnd,
  input logic               icpCellOk,
  input logic [LINK_W-1:0]  refLink,
  input logic               autoMode,
  input logic [COUNT_W-1:0] rateOut,
  input logic               rateDone
);

  AST_OUT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rateOut) |-> rateDone); // R4

  AST_WRITE_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> !rateDone); // R6

  AST_REF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgAddr) |=> (refLink == $past(cfgWrData[LINK_W-1:0]))); // R5

  AST_BAD_CELL_KEEPS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (icpCellEnd && !icpCellOk && !cfgWrEn) |=> $stable(refLink)); // R8

  AST_MANUAL_KEEPS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (!autoMode && !cfgWrEn) |=> $stable(refLink)); // R9

endmodule

bind refrate_integrator rri_checker #(
  .LINK_W  (LINK_W),
  .DATA_W  (DATA_W),
  .COUNT_W (COUNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgAddr    (cfgAddr),
  .cfgWrData  (cfgWrData),
  .icpCellEnd (icpCellEnd),
  .icpCellOk  (icpCellOk),
  .refLink    (refLink),
  .autoMode   (autoMode),
  .rateOut    (rateOut),
  .rateDone   (rateDone)
);

// File: tb/refrate_integrator_bench.sv
`timescale 1ns/1ps
module refrate_integrator_bench;

  localparam int NL   = 8;
  localparam int CW   = 8;
  localparam int DW   = 16;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NL-1:0] cellStrobe;
  logic          cfgWrEn;
  logic          cfgAddr;
  logic [DW-1:0] cfgWrData;
  logic          icpOctetValid;
  logic [5:0]    icpOctetNum;
  logic [7:0]    icpOctet;
  logic          icpCellEnd;
  logic          icpCellOk;
  logic [CW-1:0] rateOut;
  logic          rateDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  refrate_integrator #(.NUM_LINKS(NL), .COUNT_W(CW), .DATA_W(DW), .PERIOD_W(16))
  u_refrate_integrator (
    .clk(clk), .rstN(rstN), .cellStrobe(cellStrobe),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .icpOctetValid(icpOctetValid), .icpOctetNum(icpOctetNum), .icpOctet(icpOctet),
    .icpCellEnd(icpCellEnd), .icpCellOk(icpCellOk),
    .rateOut(rateOut), .rateDone(rateDone)
  );

  function automatic int expRate(int cnt);
    return (cnt > MAXC) ? MAXC : cnt;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic cfgWrite(bit addr, int data);
    cellStrobe = '0;
    cfgWrEn    = 1'b1;
    cfgAddr    = addr;
    cfgWrData  = DW'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendIcp(int val, bit ok);
    cellStrobe    = '0;
    icpOctetValid = 1'b1;
    icpOctetNum   = 6'd14;
    icpOctet      = 8'(val);
    @(negedge clk);
    icpOctetValid = 1'b0;
    icpCellEnd    = 1'b1;
    icpCellOk     = ok;
    @(negedge clk);
    icpCellEnd = 1'b0;
    icpCellOk  = 1'b0;
  endtask

  function automatic logic [NL-1:0] randStrobes(int density);
    logic [NL-1:0] v;
    for (int b = 0; b < NL; b++) v[b] = ($urandom_range(99) < density);
    return v;
  endfunction

  // Runs one window of n cycles counting strobes on refIdx; optionally
  // delivers a control cell (octet at cycle 2, end at cycle 3) that must
  // not disturb the window.
  task automatic runWindow(int n, int refIdx, int density, bit icpEn,
                           int icpVal, bit icpOk, string req);
    int cnt = 0;
    int badDone = 0;
    int badHold = 0;
    int held = int'(rateOut);
    for (int i = 0; i < n; i++) begin
      cellStrobe    = randStrobes(density);
      icpOctetValid = icpEn && (i == 2);
      icpOctetNum   = 6'd14;
      icpOctet      = 8'(icpVal);
      icpCellEnd    = icpEn && (i == 3);
      icpCellOk     = icpOk;
      if (cellStrobe[refIdx]) cnt++;
      @(negedge clk);
      if (i < n - 1) begin
        if (rateDone) badDone++;
        if (int'(rateOut) != held) badHold++;
      end
    end
    cellStrobe    = '0;
    icpOctetValid = 1'b0;
    icpCellEnd    = 1'b0;
    icpCellOk     = 1'b0;
    check(badDone == 0, {req, " R2 no early done"}, badDone, 0);
    check(badHold == 0, {req, " R4 output held in window"}, badHold, 0);
    check(rateDone == 1'b1, {req, " R2 done at window end"}, int'(rateDone), 1);
    check(int'(rateOut) == expRate(cnt), {req, " R3 rate value"},
          int'(rateOut), expRate(cnt));
  endtask

  task automatic idleCheck(int cycles, string req);
    int badDone = 0;
    int held = int'(rateOut);
    int badHold = 0;
    for (int i = 0; i < cycles; i++) begin
      cellStrobe = randStrobes(70);
      @(negedge clk);
      if (rateDone) badDone++;
      if (int'(rateOut) != held) badHold++;
    end
    cellStrobe = '0;
    check(badDone == 0, {req, " no done while idle"}, badDone, 0);
    check(badHold == 0, {req, " output frozen while idle"}, badHold, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0;
    cellStrobe = '0; cfgWrEn = 1'b0; cfgAddr = 1'b0; cfgWrData = '0;
    icpOctetValid = 1'b0; icpOctetNum = '0; icpOctet = '0;
    icpCellEnd = 1'b0; icpCellOk = 1'b0;
    repeat (4) @(negedge clk);
    check(rateOut == '0, "R1 reset rateOut", int'(rateOut), 0);
    check(rateDone == 1'b0, "R1 reset rateDone", int'(rateDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    idleCheck(25, "R1 length 0 after reset");

    // R2 R3 basic windows on link 0, back to back
    cfgWrite(1'b1, 16);
    runWindow(16, 0, 50, 1'b0, 0, 1'b0, "R3 link0 first");
    runWindow(16, 0, 50, 1'b0, 0, 1'b0, "R2 link0 consecutive");

    // R5 manual link, mid-window write restarts
    cfgWrite(1'b0, 5);
    runWindow(16, 5, 30, 1'b0, 0, 1'b0, "R5 manual link5");
    for (int i = 0; i < 7; i++) begin
      cellStrobe = '1;
      @(negedge clk);
    end
    cfgWrite(1'b0, 3);
    runWindow(16, 3, 40, 1'b0, 0, 1'b0, "R5 restart mid-window");

    // R6 length 1 boundary
    cfgWrite(1'b1, 1);
    runWindow(1, 3, 50, 1'b0, 0, 1'b0, "R6 length1 a");
    runWindow(1, 3, 100, 1'b0, 0, 1'b0, "R6 length1 b");

    // Random sweep
    for (int k = 0; k < 8; k++) begin
      int n   = 1 + int'($urandom_range(39));
      int lnk = int'($urandom_range(NL - 1));
      int den = int'($urandom_range(100));
      cfgWrite(1'b0, lnk);
      cfgWrite(1'b1, n);
      runWindow(n, lnk, den, 1'b0, 0, 1'b0, "R3 random");
      runWindow(n, lnk, den, 1'b0, 0, 1'b0, "R2 random repeat");
    end

    // R10 saturation around the count limit
    cfgWrite(1'b0, 2);
    cfgWrite(1'b1, 254);
    runWindow(254, 2, 100, 1'b0, 0, 1'b0, "R10 below limit");
    cfgWrite(1'b1, 255);
    runWindow(255, 2, 100, 1'b0, 0, 1'b0, "R10 at limit");
    cfgWrite(1'b1, 300);
    runWindow(300, 2, 100, 1'b0, 0, 1'b0, "R10 saturated");

    // R7 automatic selection
    cfgWrite(1'b1, 20);
    cfgWrite(1'b0, 32'h10 | 2);
    runWindow(20, 2, 50, 1'b0, 0, 1'b0, "R7 auto starts at written link");
    sendIcp(6, 1'b1);
    runWindow(20, 6, 50, 1'b0, 0, 1'b0, "R7 auto switch to link6");
    runWindow(20, 6, 50, 1'b1, 6, 1'b1, "R7 same link no restart");
    // R8 ignored cells in automatic mode
    runWindow(20, 6, 50, 1'b1, 9, 1'b1, "R8 out-of-range link");
    runWindow(20, 6, 50, 1'b1, 3, 1'b0, "R8 bad cell");
    runWindow(20, 6, 50, 1'b0, 0, 1'b0, "R8 link kept");

    // R9 manual mode ignores cells
    cfgWrite(1'b0, 1);
    runWindow(20, 1, 50, 1'b1, 4, 1'b1, "R9 manual ignores cell");
    runWindow(20, 1, 50, 1'b0, 0, 1'b0, "R9 link kept");

    // R6 length 0 stops publishing
    cfgWrite(1'b1, 0);
    idleCheck(40, "R6 length 0");

    finishRun();
  end

endmodule